// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block shifts stereo sample pairs out onto one serial data line. It runs on a fast system clock and watches a bit clock and a word clock that arrive as plain inputs in the same clock domain. Another block or another device generates these clocks. A new data bit is launched at every bit-clock falling edge, so a receiver can sample on the rising edge. The word clock marks where each frame starts. A bit-slot counter then places the left and right sample words inside the frame. The placement follows one of five framing styles: left-justified, right-justified, I2S, DSP and TDM. Each sample word is 16, 20, 24 or 32 bits long.

A programmable slot offset moves both sample words later in the frame. The data line has an output-enable that can be dropped on every slot that carries no data bit. With these two controls, several transmitters can share one wire and each use its own time window. A power-down input silences the line at once.

The block takes a new sample pair through a valid/ready handshake at each frame start. If no pair is offered at that moment, it sends the previous pair again.

Top module: `atx_serial_tx`

## Requirements
- R1: Sample words are sent most significant bit first. The width code selects the sample length W: 0 gives 16, 1 gives 20, 2 gives 24, 3 gives 32. Only the low W bits of each 32-bit input word are sent.
- R2: The format code selects the framing: 0 left-justified, 1 right-justified, 2 I2S, 3 DSP, 4 TDM. The word clock is sampled at each bit-clock falling edge. A frame starts when that sample differs from the previous one in the start direction: low to high in every format except I2S, and high to low in I2S. The bit period that begins at that falling edge is slot 0.
- R3: Left-justified: the left word starts at slot OFF and the right word at slot H+OFF. OFF is the offset input and H is the HALF_BITS parameter (32 by default).
- R4: I2S: the left word starts at slot 1+OFF and the right word at slot H+1+OFF.
- R5: Right-justified: the left word starts at slot H-W+OFF and the right word at slot 2H-W+OFF. With OFF=0 each word ends on the last slot of its half-frame.
- R6: DSP and TDM: the left word starts at slot 1+OFF, right after the one-slot frame pulse. The right word follows it with no gap, at slot 1+OFF+W.
- R7: The data output and the output-enable change only on the system clock edge that sees a bit-clock falling edge (bit clock high on the previous edge and low on this one). The new value appears one system clock after that edge and holds for the whole bit period. Power-down is the only exception.
- R8: While tri-state mode is enabled, the output-enable is high only in slots that carry a data bit. While it is disabled, the output-enable is high in every slot. In both modes the data output is 0 on every slot that carries no data bit.
- R9: While power-down is high, the output-enable and the data output are 0 from the next clock on and ready stays low. A sample pair offered during power-down is not taken.
- R10: Ready pulses for exactly one clock at each frame start. If valid is high in that clock, the offered pair is taken and used from slot 0 of that frame. Otherwise the previously held pair is sent again.
- R11: The slot counter saturates rather than wrapping. If no new frame starts, no data slot ever recurs, however many bit periods pass.
- R12: After reset, the data output, the output-enable and ready are all 0, and no data is sent before the first frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_i | input | 1 | Power-down, silences the line |
| cfg_fmt_i | input | 3 | Framing format code |
| cfg_width_i | input | 2 | Sample width code |
| cfg_offset_i | input | OFS_W | Start slot offset |
| cfg_hiz_i | input | 1 | Tri-state mode enable |
| bclk_i | input | 1 | Bit clock, sampled by clk |
| wclk_i | input | 1 | Word clock, sampled by clk |
| s_valid_i | input | 1 | Sample pair offered |
| s_ready_o | output | 1 | Sample pair accepted this clock (frame start) |
| s_left_i | input | DATA_W | Left sample word |
| s_right_i | input | DATA_W | Right sample word |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |

## Verification
Two things can happen in the same clock: the handshake that takes a new sample pair, and the launch of slot 0. In left-justified mode with zero offset, slot 0 must already carry the most significant bit of the word being handed over in that clock. The bench provokes this in every format by offering a pair only during the first bit period of a frame. It then compares each slot's output with a value computed from the slot formulas. In the next frame it offers a different pair on the bus with valid low, and expects the earlier pair to be repeated bit for bit.

// File: rtl/atx_pkg.sv
package atx_pkg;

  typedef enum logic [2:0] {
    FMT_LEFT  = 3'd0,
    FMT_RIGHT = 3'd1,
    FMT_I2S   = 3'd2,
    FMT_DSP   = 3'd3,
    FMT_TDM   = 3'd4
  } atx_fmt_e;

  // Sample length for a width code.
  function automatic int width_of(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/atx_edge_track.sv
module atx_edge_track
  import atx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrdn,
  input  logic [2:0] fmt,
  input  logic       bclk,
  input  logic       wclk,
  output logic       fall,
  output logic       frame_start
);

  logic bclk_q;
  logic wlast_q;
  logic wlast_d;
  logic edge_dir;

  always_comb begin
    fall    = bclk_q & ~bclk;
    wlast_d = fall ? wclk : wlast_q;
    if (fmt == FMT_I2S) edge_dir = wlast_q & ~wclk;
    else                edge_dir = ~wlast_q & wclk;
    frame_start = fall & edge_dir & ~pwrdn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      wlast_q <= 1'b0;
    end else begin
      bclk_q  <= bclk;
      wlast_q <= wlast_d;
    end
  end

endmodule

// File: rtl/atx_sample_hold.sv
module atx_sample_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_left,
  input  logic [DATA_W-1:0] s_right,
  output logic              s_ready,
  output logic [DATA_W-1:0] left_now,
  output logic [DATA_W-1:0] right_now
);

  logic [DATA_W-1:0] left_q;
  logic [DATA_W-1:0] right_q;
  logic              take;

  always_comb begin
    s_ready   = frame_start;
    take      = frame_start & s_valid;
    left_now  = take ? s_left  : left_q;
    right_now = take ? s_right : right_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (take) begin
      left_q  <= s_left;
      right_q <= s_right;
    end
  end

endmodule

// File: rtl/atx_slot_gen.sv
module atx_slot_gen #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrdn,
  input  logic              fall,
  input  logic              frame_start,
  output logic [SLOT_W-1:0] slot_now
);

  localparam logic [SLOT_W-1:0] SLOT_SAT = '1;

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    if (frame_start)             slot_now = '0;
    else if (slot_q == SLOT_SAT) slot_now = SLOT_SAT;
    else                         slot_now = slot_q + 1'b1;

    if (pwrdn)     slot_d = SLOT_SAT;
    else if (fall) slot_d = slot_now;
    else           slot_d = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= SLOT_SAT;
    else        slot_q <= slot_d;
  end

endmodule

// File: rtl/atx_bit_sel.sv
module atx_bit_sel
  import atx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int HALF_BITS = 32,
  parameter int OFS_W     = 6,
  parameter int SLOT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrdn,
  input  logic              adv,
  input  logic [SLOT_W-1:0] slot,
  input  logic [2:0]        fmt,
  input  logic [1:0]        wcode,
  input  logic [OFS_W-1:0]  offset,
  input  logic              hiz,
  input  logic [DATA_W-1:0] left,
  input  logic [DATA_W-1:0] right,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int IDX_W = $clog2(DATA_W);

  int             w;
  int             ofs;
  int             s;
  int             ls;
  int             rs;
  logic           in_l;
  logic           in_r;
  logic [IDX_W-1:0] idx_l;
  logic [IDX_W-1:0] idx_r;
  logic           sdo_q;
  logic           oe_q;
  logic           sdo_d;
  logic           oe_d;

  // Window starts for each framing style.
  always_comb begin
    w   = width_of(wcode);
    ofs = int'(offset);
    s   = int'(slot);
    case (fmt)
      FMT_RIGHT: begin
        ls = HALF_BITS - w + ofs;
        rs = 2 * HALF_BITS - w + ofs;
      end
      FMT_I2S: begin
        ls = 1 + ofs;
        rs = HALF_BITS + 1 + ofs;
      end
      FMT_DSP, FMT_TDM: begin
        ls = 1 + ofs;
        rs = 1 + ofs + w;
      end
      default: begin
        ls = ofs;
        rs = HALF_BITS + ofs;
      end
    endcase
    in_l  = (s >= ls) && (s < ls + w);
    in_r  = (s >= rs) && (s < rs + w);
    idx_l = IDX_W'(ls + w - 1 - s);
    idx_r = IDX_W'(rs + w - 1 - s);
  end

  always_comb begin
    sdo_d = sdo_q;
    oe_d  = oe_q;
    if (pwrdn) begin
      sdo_d = 1'b0;
      oe_d  = 1'b0;
    end else if (adv) begin
      if (in_l) begin
        sdo_d = left[idx_l];
        oe_d  = 1'b1;
      end else if (in_r) begin
        sdo_d = right[idx_r];
        oe_d  = 1'b1;
      end else begin
        sdo_d = 1'b0;
        oe_d  = ~hiz;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      sdo_q <= sdo_d;
      oe_q  <= oe_d;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = oe_q;

endmodule

// File: rtl/atx_serial_tx.sv
module atx_serial_tx #(
  parameter int DATA_W    = 32,
  parameter int HALF_BITS = 32,
  parameter int OFS_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrdn_i,
  input  logic [2:0]        cfg_fmt_i,
  input  logic [1:0]        cfg_width_i,
  input  logic [OFS_W-1:0]  cfg_offset_i,
  input  logic              cfg_hiz_i,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_left_i,
  input  logic [DATA_W-1:0] s_right_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);

  // Longest window end plus one spare value for saturation.
  localparam int SLOT_W = $clog2(2 * HALF_BITS + (1 << OFS_W) + 2);

  logic              rst_meta;
  logic              rst_sync;
  logic              fall;
  logic              frame_start;
  logic [SLOT_W-1:0] slot_now;
  logic [DATA_W-1:0] left_now;
  logic [DATA_W-1:0] right_now;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  atx_edge_track u_edge (
    .clk         (clk),
    .rst_n       (rst_sync),
    .pwrdn       (pwrdn_i),
    .fmt         (cfg_fmt_i),
    .bclk        (bclk_i),
    .wclk        (wclk_i),
    .fall        (fall),
    .frame_start (frame_start)
  );

  atx_sample_hold #(.DATA_W(DATA_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_sync),
    .frame_start (frame_start),
    .s_valid     (s_valid_i),
    .s_left      (s_left_i),
    .s_right     (s_right_i),
    .s_ready     (s_ready_o),
    .left_now    (left_now),
    .right_now   (right_now)
  );

  atx_slot_gen #(.SLOT_W(SLOT_W)) u_slot (
    .clk         (clk),
    .rst_n       (rst_sync),
    .pwrdn       (pwrdn_i),
    .fall        (fall),
    .frame_start (frame_start),
    .slot_now    (slot_now)
  );

  atx_bit_sel #(
    .DATA_W    (DATA_W),
    .HALF_BITS (HALF_BITS),
    .OFS_W     (OFS_W),
    .SLOT_W    (SLOT_W)
  ) u_bits (
    .clk    (clk),
    .rst_n  (rst_sync),
    .pwrdn  (pwrdn_i),
    .adv    (fall),
    .slot   (slot_now),
    .fmt    (cfg_fmt_i),
    .wcode  (cfg_width_i),
    .offset (cfg_offset_i),
    .hiz    (cfg_hiz_i),
    .left   (left_now),
    .right  (right_now),
    .sdo    (sdo_o),
    .sdo_oe (sdo_oe_o)
  );

endmodule

// File: rtl/atx_serial_tx_chk.sv
module atx_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic pwrdn_i,
  input logic bclk_i,
  input logic s_ready_o,
  input logic sdo_o,
  input logic sdo_oe_o
);

  // R7: outputs move only after a sampled bit-clock fall (or power-down)
  a_r7_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!($past(bclk_i, 2) && !$past(bclk_i)) && !$past(pwrdn_i))
      |-> ($stable(sdo_o) && $stable(sdo_oe_o)));

  // R9: power-down silences the line on the next clock
  a_r9_pwrdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwrdn_i) |-> (!sdo_oe_o && !sdo_o));

  // R9: no handshake while powered down
  a_r9_no_ready_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_i |-> !s_ready_o);

  // R10: ready only in the clock that sees a bit-clock fall
  a_r10_ready_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> ($past(bclk_i) && !bclk_i));

  // R8: a released line carries 0
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe_o |-> !sdo_o);

endmodule

bind atx_serial_tx atx_serial_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwrdn_i   (pwrdn_i),
  .bclk_i    (bclk_i),
  .s_ready_o (s_ready_o),
  .sdo_o     (sdo_o),
  .sdo_oe_o  (sdo_oe_o)
);

// File: tb/atx_serial_tx_tb.sv
`timescale 1ns/1ps
module atx_serial_tx_tb;

  logic        clk;
  logic        rst_n;
  logic        pwrdn_i;
  logic [2:0]  cfg_fmt_i;
  logic [1:0]  cfg_width_i;
  logic [5:0]  cfg_offset_i;
  logic        cfg_hiz_i;
  logic        bclk_i;
  logic        wclk_i;
  logic        s_valid_i;
  logic        s_ready_o;
  logic [31:0] s_left_i;
  logic [31:0] s_right_i;
  logic        sdo_o;
  logic        sdo_oe_o;

  int checks;
  int fails;
  int ready_cnt;

  atx_serial_tx u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwrdn_i      (pwrdn_i),
    .cfg_fmt_i    (cfg_fmt_i),
    .cfg_width_i  (cfg_width_i),
    .cfg_offset_i (cfg_offset_i),
    .cfg_hiz_i    (cfg_hiz_i),
    .bclk_i       (bclk_i),
    .wclk_i       (wclk_i),
    .s_valid_i    (s_valid_i),
    .s_ready_o    (s_ready_o),
    .s_left_i     (s_left_i),
    .s_right_i    (s_right_i),
    .sdo_o        (sdo_o),
    .sdo_oe_o     (sdo_oe_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) if (s_ready_o) ready_cnt <= ready_cnt + 1;

  initial begin
    #3000000;
    fails = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(input bit ok, input string msg);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s", msg);
    end
  endtask

  // Expected {oe, sdo} for slot s.
  function automatic logic [1:0] expect_slot(input int fmt, input int wc, input int off,
      input bit hiz, input logic [31:0] l, input logic [31:0] r, input int s);
    int w;
    int ls;
    int rs;
    w = (wc == 0) ? 16 : (wc == 1) ? 20 : (wc == 2) ? 24 : 32;
    case (fmt)
      0: begin ls = off; rs = 32 + off; end
      1: begin ls = 32 - w + off; rs = 64 - w + off; end
      2: begin ls = 1 + off; rs = 33 + off; end
      default: begin ls = 1 + off; rs = 1 + off + w; end
    endcase
    if (s >= ls && s < ls + w) return {1'b1, l[ls + w - 1 - s]};
    if (s >= rs && s < rs + w) return {1'b1, r[rs + w - 1 - s]};
    return {~hiz, 1'b0};
  endfunction

  function automatic logic wlevel(input int fmt, input int s);
    if (fmt == 2) return s >= 32;
    if (fmt >= 3) return s == 0;
    return s < 32;
  endfunction

  // One bit period; a = value just after the launch edge, b = value at its end.
  task automatic bit_period(input logic w, output logic [1:0] a, output logic [1:0] b);
    @(negedge clk);
    bclk_i = 1'b0;
    wclk_i = w;
    @(negedge clk);
    a = {sdo_oe_o, sdo_o};
    repeat (3) @(negedge clk);
    bclk_i = 1'b1;
    repeat (3) @(negedge clk);
    b = {sdo_oe_o, sdo_o};
  endtask

  task automatic run_frame(input int fmt, input int wc, input int off, input bit hiz,
      input bit pd, input bit valid, input logic [31:0] bus_l, input logic [31:0] bus_r,
      input logic [31:0] exp_l, input logic [31:0] exp_r, input string tag);
    logic [1:0] a;
    logic [1:0] b;
    logic [1:0] e;
    int n;
    int r0;
    int bad_slot;
    logic [1:0] bad_a;
    logic [1:0] bad_e;
    bit stable_ok;
    n = (fmt >= 3) ? 72 : 64;
    cfg_fmt_i    = 3'(fmt);
    cfg_width_i  = 2'(wc);
    cfg_offset_i = 6'(off);
    cfg_hiz_i    = hiz;
    pwrdn_i      = pd;
    bit_period((fmt == 2) ? 1'b1 : 1'b0, a, b);
    s_valid_i = valid;
    s_left_i  = bus_l;
    s_right_i = bus_r;
    r0 = ready_cnt;
    bad_slot = -1;
    bad_a = '0;
    bad_e = '0;
    stable_ok = 1'b1;
    for (int s = 0; s < n; s++) begin
      bit_period(wlevel(fmt, s), a, b);
      if (s == 0) s_valid_i = 1'b0;
      e = pd ? 2'b00 : expect_slot(fmt, wc, off, hiz, exp_l, exp_r, s);
      if (a != e && bad_slot < 0) begin
        bad_slot = s;
        bad_a = a;
        bad_e = e;
      end
      if (a != b) stable_ok = 1'b0;
    end
    check(bad_slot < 0, $sformatf("%s fmt=%0d wc=%0d off=%0d slot=%0d oe,sdo actual=%b expected=%b",
      tag, fmt, wc, off, bad_slot, bad_a, bad_e));
    check(stable_ok, $sformatf("R7 output moved inside a bit period fmt=%0d actual=moved expected=stable", fmt));
    check((ready_cnt - r0) == (pd ? 0 : 1),
      $sformatf("R10 ready pulses fmt=%0d actual=%0d expected=%0d", fmt, ready_cnt - r0, pd ? 0 : 1));
  endtask

  initial begin
    logic [31:0] l1;
    logic [31:0] r1;
    logic [1:0]  a;
    logic [1:0]  b;
    bit          idle_ok;
    string       tag;
    checks = 0;
    fails = 0;
    ready_cnt = 0;
    rst_n = 1'b0;
    pwrdn_i = 1'b0;
    cfg_fmt_i = 3'd0;
    cfg_width_i = 2'd3;
    cfg_offset_i = 6'd0;
    cfg_hiz_i = 1'b1;
    bclk_i = 1'b1;
    wclk_i = 1'b0;
    s_valid_i = 1'b0;
    s_left_i = '0;
    s_right_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    check(sdo_oe_o == 1'b0, $sformatf("R12 reset oe actual=%b expected=0", sdo_oe_o));
    check(sdo_o == 1'b0, $sformatf("R12 reset sdo actual=%b expected=0", sdo_o));
    check(s_ready_o == 1'b0, $sformatf("R12 reset ready actual=%b expected=0", s_ready_o));
    // R12: periods with no frame start drive nothing
    idle_ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      bit_period(1'b0, a, b);
      if (a != 2'b00) idle_ok = 1'b0;
    end
    check(idle_ok, "R12 no data before first frame actual=driven expected=quiet");

    // Sweep: R1 R2 framing per format, then R10 repeat with valid low
    for (int fmt = 0; fmt < 5; fmt++) begin
      for (int wc = 0; wc < 4; wc++) begin
        for (int oi = 0; oi < 2; oi++) begin
          l1 = 32'hA5C3_0F96 ^ (32'(fmt) << 24) ^ (32'(wc) << 8) ^ 32'(oi * 3);
          r1 = 32'h3C5A_E11D ^ (32'(fmt) << 16) ^ (32'(wc) << 4) ^ 32'(oi * 5);
          case (fmt)
            0: tag = "R1 R2 R3 left-justified";
            1: tag = "R1 R2 R5 right-justified";
            2: tag = "R1 R2 R4 i2s";
            default: tag = "R1 R2 R6 dsp/tdm";
          endcase
          run_frame(fmt, wc, oi * 2, 1'b1, 1'b0, 1'b1, l1, r1, l1, r1, tag);
          run_frame(fmt, wc, oi * 2, 1'b1, 1'b0, 1'b0, ~l1, ~r1, l1, r1, "R10 repeat held pair");
        end
      end
    end

    // R8 tri-state disabled: enable high in every slot
    l1 = 32'h1234_5678;
    r1 = 32'h9ABC_DEF0;
    run_frame(0, 0, 5, 1'b0, 1'b0, 1'b1, l1, r1, l1, r1, "R8 tri-state off");

    // R11: no wrap after long silence
    idle_ok = 1'b1;
    for (int i = 0; i < 300; i++) begin
      cfg_hiz_i = 1'b1;
      bit_period(1'b0, a, b);
      if (a != 2'b00) idle_ok = 1'b0;
    end
    check(idle_ok, "R11 slot counter wrapped actual=data expected=quiet");

    // R9 power-down: line silent, offered pair ignored
    run_frame(3, 1, 0, 1'b0, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'hFEED_F00D, l1, r1, "R9 power-down");
    run_frame(3, 1, 0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, l1, r1, "R9 pair kept through power-down");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule